// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves the branch-format instructions of a 16-bit processor. When the sequencer presents an instruction word together with the program counter, the block first checks whether the word is a relative jump. The program counter it receives has already been advanced past the jump word. If the word is a jump, the block tests a 3-bit condition field against the N, Z, C and V status bits. It then reports whether the branch is taken and which address fetch should continue from.

A jump is accepted on a `start` pulse. The block is busy for two cycles and then raises `done` for one cycle. It takes the same time whether the branch is taken or not. The 10-bit offset field counts words, so the block scales it by two before adding it to the incremented program counter. The status bits leave the block exactly as they entered, so a jump never changes the flags.

Top module: `rel_jump_unit`

## Requirements
- R1: A `start` whose instruction bits [15:13] differ from 3'b001 is rejected: `busy` stays low, `done` does not pulse, and `taken`, `next_pc` and `flags_out` keep their previous values.
- R2: A jump accepted at clock edge k drives `busy` high after edges k and k+1. After edge k+2, `busy` is low and `done` is high for exactly one cycle. This timing is the same for taken and not-taken jumps.
- R3: The condition sits in instruction bits [12:10], and flags use the order {N,Z,C,V} on bits [3:0]. The branch is taken as follows: 000 if Z=0, 001 if Z=1, 010 if C=0, 011 if C=1, 100 if N=1, 101 if N equals V, 110 if N differs from V, and 111 always.
- R4: A taken jump sets `next_pc` to `pc_inc` plus twice the sign-extended two's-complement offset in bits [9:0], modulo 2^16. For example, an offset of -4 with `pc_inc` 0xC012 gives 0xC00A.
- R5: A jump that is not taken sets `next_pc` equal to `pc_inc` exactly.
- R6: The target of a taken jump always has bit 0 cleared, even when `pc_inc` is odd.
- R7: When `done` is high, `flags_out` equals the `flags_in` value captured at acceptance, unmodified.
- R8: A `start` that arrives while `busy` is high is ignored, and the result belongs to the jump already in flight.
- R9: After reset, `busy`, `done`, `taken`, `next_pc` and `flags_out` are all zero.
- R10: The block captures `instr`, `pc_inc` and `flags_in` at acceptance. Later changes to these inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to resolve the presented word |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter already advanced past the word |
| flags_in | input | 4 | Status bits {N,Z,C,V} |
| busy | output | 1 | Jump in flight |
| done | output | 1 | One-cycle result strobe |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Address to fetch next |
| flags_out | output | 4 | Status bits passed through unchanged |

## Verification
The bench sweeps every condition code against all sixteen flag combinations. A swapped condition pair or a mixed-up N/V test would give the wrong taken value there. The offset extremes +511 and -512 and an address wrap target the scaling. A design that forgot to double the offset, or extended it as unsigned, would land on the wrong word. An odd incremented program counter shows whether the target's low bit is cleared and whether the not-taken path still passes the value through untouched. Non-jump words, a second start in mid-flight, and inputs changing during the busy window test the capture logic; a careless design would start spuriously or mix two requests.

// File: rtl/rju_pkg.sv
package rju_pkg;

  localparam int COND_W = 3;

  // flag bit positions within the {N,Z,C,V} status vector
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
  localparam int FL_W = 4;

  typedef enum logic [COND_W-1:0] {
    JC_ZERO_CLR = 3'b000,
    JC_ZERO_SET = 3'b001,
    JC_CARRY_CLR = 3'b010,
    JC_CARRY_SET = 3'b011,
    JC_NEG       = 3'b100,
    JC_GE        = 3'b101,
    JC_LT        = 3'b110,
    JC_ALWAYS    = 3'b111
  } jcond_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EVAL    = 2'd1,
    ST_RESOLVE = 2'd2
  } jstate_e;

endpackage

// File: rtl/rju_cond_eval.sv
module rju_cond_eval
  import rju_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FL_W-1:0]   flags,
  output logic              take
);

  logic fn, fz, fc, fv;
  assign fn = flags[FL_N];
  assign fz = flags[FL_Z];
  assign fc = flags[FL_C];
  assign fv = flags[FL_V];

  always_comb begin
    case (jcond_e'(cond))
      JC_ZERO_CLR:  take = ~fz;
      JC_ZERO_SET:  take = fz;
      JC_CARRY_CLR: take = ~fc;
      JC_CARRY_SET: take = fc;
      JC_NEG:       take = fn;
      JC_GE:        take = ~(fn ^ fv);
      JC_LT:        take = fn ^ fv;
      default:      take = 1'b1;
    endcase
  end

endmodule

// File: rtl/rju_target_gen.sv
module rju_target_gen #(
  parameter int WORD_W = 16,
  parameter int OFFS_W = 10
) (
  input  logic [WORD_W-2:0] pc_word,
  input  logic [OFFS_W-1:0] offset,
  output logic [WORD_W-1:0] target
);

  localparam int EXT_W = WORD_W - 1 - OFFS_W;

  logic [WORD_W-2:0] off_word;
  logic [WORD_W-2:0] sum_word;

  // work in word units: the offset needs no shift, the byte LSB is zero
  generate
    if (EXT_W > 0) begin : g_ext
      assign off_word = {{EXT_W{offset[OFFS_W-1]}}, offset};
    end else begin : g_noext
      assign off_word = offset[WORD_W-2:0];
    end
  endgenerate

  assign sum_word = pc_word + off_word;
  assign target   = {sum_word, 1'b0};

endmodule

// File: rtl/rju_seq.sv
module rju_seq
  import rju_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_jump,
  output logic load,
  output logic eval_en,
  output logic fin,
  output logic busy
);

  jstate_e state_q;

  assign load    = (state_q == ST_IDLE) && start && is_jump;
  assign eval_en = (state_q == ST_EVAL);
  assign fin     = (state_q == ST_RESOLVE);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:    if (load) state_q <= ST_EVAL;
        ST_EVAL:    state_q <= ST_RESOLVE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rel_jump_unit.sv
module rel_jump_unit
  import rju_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int OFFS_W  = 10,
  parameter int TAG_W   = 3,
  parameter logic [TAG_W-1:0] JUMP_TAG = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc_inc,
  input  logic [3:0]        flags_in,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [WORD_W-1:0] next_pc,
  output logic [3:0]        flags_out
);

  localparam int TAG_LSB  = WORD_W - TAG_W;
  localparam int COND_LSB = OFFS_W;

  logic              is_jump;
  logic              load, eval_en, fin;
  logic [COND_W-1:0] cond_q;
  logic [OFFS_W-1:0] off_q;
  logic [WORD_W-1:0] pc_q;
  logic [FL_W-1:0]   flg_q;
  logic              take_w, take_q;
  logic [WORD_W-1:0] tgt_w, tgt_q;

  assign is_jump = (instr[WORD_W-1:TAG_LSB] == JUMP_TAG);

  rju_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_jump (is_jump),
    .load    (load),
    .eval_en (eval_en),
    .fin     (fin),
    .busy    (busy)
  );

  rju_cond_eval u_cond (
    .cond  (cond_q),
    .flags (flg_q),
    .take  (take_w)
  );

  rju_target_gen #(
    .WORD_W (WORD_W),
    .OFFS_W (OFFS_W)
  ) u_tgt (
    .pc_word (pc_q[WORD_W-1:1]),
    .offset  (off_q),
    .target  (tgt_w)
  );

  // stage 0: capture the request
  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      off_q  <= '0;
      pc_q   <= '0;
      flg_q  <= '0;
    end else if (load) begin
      cond_q <= instr[COND_LSB +: COND_W];
      off_q  <= instr[OFFS_W-1:0];
      pc_q   <= pc_inc;
      flg_q  <= flags_in;
    end
  end

  // stage 1: condition and target
  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      tgt_q  <= '0;
    end else if (eval_en) begin
      take_q <= take_w;
      tgt_q  <= tgt_w;
    end
  end

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      flags_out <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        taken     <= take_q;
        next_pc   <= take_q ? tgt_q : pc_q;
        flags_out <= flg_q;
      end
    end
  end

endmodule

// File: rtl/rju_chk.sv
module rju_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] pc_inc,
  input logic [3:0]        flags_in,
  input logic              busy,
  input logic              done,
  input logic              taken,
  input logic [WORD_W-1:0] next_pc,
  input logic [3:0]        flags_out
);

  // R2: two busy cycles, then done with busy low
  a_r2_busy_then_done: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (busy ##1 (done && !busy)));

  // R2: done is a single-cycle strobe
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: non-jump word never starts the unit
  a_r1_reject: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && instr[WORD_W-1:WORD_W-3] != 3'b001) |=> !busy);

  // R7: flags leave unchanged from the acceptance edge
  a_r7_flags_pass: assert property (@(posedge clk) disable iff (rst)
    done |-> flags_out == $past(flags_in, 3));

  // R5: not taken keeps the incremented pc
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (done && !taken) |-> next_pc == $past(pc_inc, 3));

  // R6: taken target is word aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
    (done && taken) |-> !next_pc[0]);

  // R8: results hold while a jump is in flight
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(next_pc) && $stable(taken)));

endmodule

bind rel_jump_unit rju_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .instr     (instr),
  .pc_inc    (pc_inc),
  .flags_in  (flags_in),
  .busy      (busy),
  .done      (done),
  .taken     (taken),
  .next_pc   (next_pc),
  .flags_out (flags_out)
);

// File: tb/sim_rel_jump_unit.sv
`timescale 1ns/1ps
module sim_rel_jump_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_inc = '0;
  logic [3:0]  flags_in = '0;
  logic        busy, done, taken;
  logic [15:0] next_pc;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rel_jump_unit u0 (
    .clk (clk), .rst (rst), .start (start), .instr (instr),
    .pc_inc (pc_inc), .flags_in (flags_in), .busy (busy), .done (done),
    .taken (taken), .next_pc (next_pc), .flags_out (flags_out)
  );

  function automatic bit exp_take(input logic [2:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] ins, input logic [15:0] pc,
                                         input logic [3:0] f);
    logic [15:0] t;
    if (!exp_take(ins[12:10], f)) return pc;
    t = pc + {{5{ins[9]}}, ins[9:0], 1'b0};
    return {t[15:1], 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one accepted jump; disturb changes inputs and pulses start mid-flight
  task automatic run_jump(input logic [15:0] ins, input logic [15:0] pc,
                          input logic [3:0] fl, input bit disturb, input string req);
    bit          et = exp_take(ins[12:10], fl);
    logic [15:0] ep = exp_pc(ins, pc, fl);
    @(negedge clk);
    start = 1'b1; instr = ins; pc_inc = pc; flags_in = fl;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 busy after accept", {busy, done}, 2'b10);
    if (disturb) begin
      start = 1'b1;
      instr = {3'b001, 13'($urandom)};
      pc_inc = 16'($urandom);
      flags_in = 4'($urandom);
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 second busy cycle", {busy, done}, 2'b10);
    @(negedge clk);
    chk(done && !busy, "R2 done strobe", {busy, done}, 2'b01);
    chk(taken == et, {req, " taken"}, taken, et);
    chk(next_pc == ep, {req, " next_pc"}, next_pc, ep);
    chk(flags_out == fl, "R7 flags unchanged", flags_out, fl);
    @(negedge clk);
    chk(!done, "R2 done one cycle", done, 0);
  endtask

  initial begin
    logic [15:0] hold_pc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk({busy, done, taken} == 3'b000, "R9 reset controls", {busy, done, taken}, 0);
    chk(next_pc == 16'h0 && flags_out == 4'h0, "R9 reset data", {next_pc, flags_out}, 0);

    // R4 worked example: offset -4 at 0xC012
    run_jump(16'h3FFC, 16'hC012, 4'h0, 0, "R4 example");
    chk(next_pc == 16'hC00A, "R4 example value", next_pc, 16'hC00A);

    // R3 every condition against every flag pattern
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        run_jump({3'b001, 3'(c), 10'h005}, 16'h8000, 4'(f), 0, "R3 cond sweep");

    // R4 offset extremes and wrap
    run_jump({3'b001, 3'b111, 10'h1FF}, 16'h1000, 4'h0, 0, "R4 max forward");
    chk(next_pc == 16'h13FE, "R4 +511 words", next_pc, 16'h13FE);
    run_jump({3'b001, 3'b111, 10'h200}, 16'h1000, 4'h0, 0, "R4 max backward");
    chk(next_pc == 16'h0C00, "R4 -512 words", next_pc, 16'h0C00);
    run_jump({3'b001, 3'b111, 10'h3FF}, 16'h0000, 4'h0, 0, "R4 wrap");
    chk(next_pc == 16'hFFFE, "R4 wrap value", next_pc, 16'hFFFE);

    // R6 odd pc with taken jump, R5 odd pc with not-taken jump
    run_jump({3'b001, 3'b111, 10'h002}, 16'h2001, 4'h0, 0, "R6 odd pc taken");
    chk(next_pc == 16'h2004, "R6 lsb cleared", next_pc, 16'h2004);
    run_jump({3'b001, 3'b001, 10'h002}, 16'h2001, 4'h0, 0, "R5 odd pc not taken");
    chk(next_pc == 16'h2001, "R5 passthrough", next_pc, 16'h2001);

    // R1 non-jump words are ignored
    hold_pc = next_pc;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (w[15:13] == 3'b001) w[15] = 1'b1;
      @(negedge clk);
      start = 1'b1; instr = w; pc_inc = 16'($urandom); flags_in = 4'($urandom);
      @(negedge clk);
      start = 1'b0;
      chk(!busy, "R1 no busy on non-jump", busy, 0);
      @(negedge clk);
      @(negedge clk);
      chk(!done && !busy, "R1 no done on non-jump", {busy, done}, 0);
      chk(next_pc == hold_pc, "R1 outputs held", next_pc, hold_pc);
    end

    // R8 and R10: start and input changes during flight
    run_jump({3'b001, 3'b000, 10'h010}, 16'h4000, 4'b0000, 1, "R8 mid-flight start");
    run_jump({3'b001, 3'b110, 10'h3F0}, 16'h5002, 4'b1000, 1, "R10 inputs changed");

    // random mix
    for (int k = 0; k < 300; k++)
      run_jump({3'b001, 13'($urandom)}, {15'($urandom), 1'b0}, 4'($urandom),
               bit'($urandom), "R3 R4 random");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule